// File: doc/BRIEF.md
# Chip-Select Assertion Extension Sequencer

This block runs external bus cycles for an address map split into eight areas. Each area has its own active-low chip select. An internal master starts an access by giving the area number, the address, the direction and the write data. The block then drives the external address, the area's chip select, the read or write strobe and the data bus, and it reports completion with a one-cycle done pulse.

Two configuration registers each hold one bit per area. A bit in the lead register adds a single setup state before the strobe cycle of that area. A bit in the trail register adds a single hold state after the strobe cycle. During these added states only the chip select and the address are active and both strobes stay high, so slow peripherals see a wider address and select window. The area's two bits are captured when an access starts, so software can change the configuration at any time without corrupting an access that is already running.

A normal access takes two states. In the first, the address and select are driven. In the second, the strobe is low and read data is sampled at the end of that state.

Top module: `cs_ext_seq`

## Requirements
- R1: After reset all chip selects, `bus_rd_n` and `bus_wr_n` are high, `done` and `bus_doe` are low, and both configuration registers read back 0.
- R2: A configuration write with `cfg_sel`=0 loads the lead (pre-state) register and one with `cfg_sel`=1 loads the trail (post-state) register. `cfg_rdata` shows the register chosen by `cfg_sel` one clock later.
- R3: During an access only `bus_cs_n[area]` is low. It stays low for a contiguous window of 2 + pre + post cycles, where pre and post are bit `area` of the lead and trail registers. `bus_addr` holds the request address and is stable across the whole window.
- R4: When the lead bit of the accessed area is 1, exactly one select-only cycle comes first in the window, and the strobe falls in window cycle 2 instead of cycle 1. Bits of other areas have no effect.
- R5: When the trail bit of the accessed area is 1, exactly one select-only cycle follows the strobe cycle before the chip select rises.
- R6: Exactly one strobe cycle occurs per access. It is `bus_rd_n` low for a read or `bus_wr_n` low for a write, never both, and never in an added pre-state or post-state.
- R7: For a write, `bus_doe` is high and `bus_dout` equals the write data from the strobe cycle through the last window cycle. For a read, `bus_doe` stays low.
- R8: For a read, the value on `bus_din` during the strobe cycle is sampled and shown on `rd_data` no later than the done cycle.
- R9: `done` is high for exactly the one cycle right after the select window, with all chip selects high in that cycle.
- R10: A `req_start` seen while an access is running is ignored. No second window follows.
- R11: A configuration write during an access does not change that access. It applies from the next access onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | 0 selects the lead register, 1 the trail register |
| cfg_wdata | input | NUM_AREAS | Configuration write data, bit n for area n |
| cfg_rdata | output | NUM_AREAS | Registered read-back of the selected register |
| req_start | input | 1 | Start an access (taken only when idle) |
| req_area | input | AREA_W | Area number of the access |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | NUM_AREAS | Active-low chip selects, one per area |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_dout | output | DATA_W | Write data to the external bus |
| bus_doe | output | 1 | Write data drive enable |
| bus_din | input | DATA_W | Read data from the external bus |

## Verification
Accesses are run with neither, only the lead, only the trail and both extension bits set for the accessed area. Window length and strobe position then show whether a setup state, a hold state or both were added. A neighbouring area is accessed while only another area's bit is set, which tells per-area decoding apart from a shared enable. Reads and writes in the same settings separate strobe choice, data-drive span and read capture. A start pulse sent mid-access and a register write mid-access show whether requests and configuration changes leak into a running access or take effect only at the next one.

// File: rtl/cs_ext_pkg.sv
package cs_ext_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ADR,
    ST_STB,
    ST_POST,
    ST_DONE
  } seq_state_e;
endpackage

// File: rtl/cs_ext_cfg.sv
module cs_ext_cfg #(
  parameter int NUM_AREAS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic                 sel,
  input  logic [NUM_AREAS-1:0] wdata,
  output logic [NUM_AREAS-1:0] rdata,
  output logic [NUM_AREAS-1:0] lead_vec,
  output logic [NUM_AREAS-1:0] trail_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      lead_vec  <= '0;
      trail_vec <= '0;
      rdata     <= '0;
    end else begin
      if (we && !sel) lead_vec  <= wdata;
      if (we && sel)  trail_vec <= wdata;
      rdata <= sel ? trail_vec : lead_vec;
    end
  end
endmodule

// File: rtl/cs_ext_decode.sv
module cs_ext_decode #(
  parameter int NUM_AREAS = 8,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic [AREA_W-1:0]    area,
  output logic [NUM_AREAS-1:0] onehot
);
  for (genvar i = 0; i < NUM_AREAS; i++) begin : g_dec
    assign onehot[i] = (area == AREA_W'(i));
  end
endmodule

// File: rtl/cs_ext_fsm.sv
module cs_ext_fsm
  import cs_ext_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AREA_W-1:0]    area,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 write,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_AREAS-1:0] lead_vec,
  input  logic [NUM_AREAS-1:0] trail_vec,
  input  logic [NUM_AREAS-1:0] area_mask,
  output logic [AREA_W-1:0]    area_eff,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 done,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_AREAS-1:0] bus_cs_n,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_doe,
  input  logic [DATA_W-1:0]    bus_din
);
  seq_state_e state, nxt;

  logic [AREA_W-1:0] area_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q, lead_q, trail_q;

  logic              accept;
  logic [ADDR_W-1:0] addr_eff;
  logic [DATA_W-1:0] wdata_eff;
  logic              wr_eff, lead_eff, trail_eff, in_win_nxt;

  assign accept    = (state == ST_IDLE) && start;
  assign area_eff  = accept ? area : area_q;
  assign addr_eff  = accept ? addr : addr_q;
  assign wdata_eff = accept ? wdata : wdata_q;
  assign wr_eff    = accept ? write : wr_q;
  assign lead_eff  = accept ? lead_vec[area] : lead_q;
  assign trail_eff = accept ? trail_vec[area] : trail_q;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (accept) nxt = lead_eff ? ST_PRE : ST_ADR;
      ST_PRE:  nxt = ST_ADR;
      ST_ADR:  nxt = ST_STB;
      ST_STB:  nxt = trail_eff ? ST_POST : ST_DONE;
      ST_POST: nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign in_win_nxt = (nxt == ST_PRE) || (nxt == ST_ADR) ||
                      (nxt == ST_STB) || (nxt == ST_POST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      area_q   <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      wr_q     <= 1'b0;
      lead_q   <= 1'b0;
      trail_q  <= 1'b0;
      rd_data  <= '0;
      done     <= 1'b0;
      bus_addr <= '0;
      bus_cs_n <= '1;
      bus_rd_n <= 1'b1;
      bus_wr_n <= 1'b1;
      bus_dout <= '0;
      bus_doe  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        area_q  <= area;
        addr_q  <= addr;
        wdata_q <= wdata;
        wr_q    <= write;
        lead_q  <= lead_vec[area];
        trail_q <= trail_vec[area];
      end
      if (state == ST_STB && !wr_q) rd_data <= bus_din;
      done     <= (nxt == ST_DONE);
      bus_cs_n <= in_win_nxt ? ~area_mask : '1;
      if (in_win_nxt) bus_addr <= addr_eff;
      bus_rd_n <= !((nxt == ST_STB) && !wr_eff);
      bus_wr_n <= !((nxt == ST_STB) && wr_eff);
      bus_doe  <= wr_eff && ((nxt == ST_STB) || (nxt == ST_POST));
      bus_dout <= (wr_eff && ((nxt == ST_STB) || (nxt == ST_POST))) ? wdata_eff : '0;
    end
  end

  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~bus_cs_n));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(&bus_cs_n) && !(&$past(bus_cs_n))) |-> $stable(bus_addr));

  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && !bus_wr_n));

  // R6
  strobe_in_win_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || !bus_wr_n) |-> !(&bus_cs_n));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (&bus_cs_n));

  // R7
  doe_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    bus_doe |-> (bus_rd_n && !(&bus_cs_n)));
endmodule

// File: rtl/cs_ext_seq.sv
module cs_ext_seq #(
  parameter int NUM_AREAS = 8,
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 16,
  localparam int AREA_W = $clog2(NUM_AREAS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic                 cfg_sel,
  input  logic [NUM_AREAS-1:0] cfg_wdata,
  output logic [NUM_AREAS-1:0] cfg_rdata,
  input  logic                 req_start,
  input  logic [AREA_W-1:0]    req_area,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_write,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 done,
  output logic [ADDR_W-1:0]    bus_addr,
  output logic [NUM_AREAS-1:0] bus_cs_n,
  output logic                 bus_rd_n,
  output logic                 bus_wr_n,
  output logic [DATA_W-1:0]    bus_dout,
  output logic                 bus_doe,
  input  logic [DATA_W-1:0]    bus_din
);
  logic [NUM_AREAS-1:0] lead_vec, trail_vec, area_mask;
  logic [AREA_W-1:0]    area_eff;

  cs_ext_cfg #(.NUM_AREAS(NUM_AREAS)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .lead_vec(lead_vec), .trail_vec(trail_vec)
  );

  cs_ext_decode #(.NUM_AREAS(NUM_AREAS)) u_dec (
    .area(area_eff), .onehot(area_mask)
  );

  cs_ext_fsm #(.NUM_AREAS(NUM_AREAS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .start(req_start), .area(req_area), .addr(req_addr),
    .write(req_write), .wdata(req_wdata), .lead_vec(lead_vec),
    .trail_vec(trail_vec), .area_mask(area_mask), .area_eff(area_eff),
    .rd_data(rd_data), .done(done), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .bus_din(bus_din)
  );
endmodule

// File: tb/cs_ext_seq_test.sv
module cs_ext_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int AW = 24;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [NA-1:0] cfg_wdata = '0, cfg_rdata;
  logic req_start = 1'b0, req_write = 1'b0;
  logic [2:0] req_area = '0;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [DW-1:0] req_wdata = '0, rd_data, bus_dout, bus_din = '0;
  logic done, bus_rd_n, bus_wr_n, bus_doe;
  logic [NA-1:0] bus_cs_n;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_ext_seq #(.NUM_AREAS(NA), .ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_start(req_start),
    .req_area(req_area), .req_addr(req_addr), .req_write(req_write),
    .req_wdata(req_wdata), .rd_data(rd_data), .done(done),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [NA-1:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input bit sel, output logic [NA-1:0] d);
    cfg_sel = sel;
    @(negedge clk);
    @(negedge clk);
    d = cfg_rdata;
  endtask

  // mode: 0 plain, 1 extra start mid-access, 2 config write mid-access
  task automatic run_access(input int area, input logic [AW-1:0] addr,
                            input bit wr, input logic [DW-1:0] wd,
                            input int pre, input int post, input int mode,
                            input string tag);
    int win_len = 0, stb_idx = -1, stb_cnt = 0, done_idx = -1, done_cnt = 0;
    int other_bad = 0, addr_bad = 0, doe_bad = 0, wrong_stb = 0, late_win = 0;
    int exp_len = 2 + pre + post;
    logic [DW-1:0] rd_at_done = '0;
    req_area = 3'(area); req_addr = addr; req_write = wr; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int c = 0; c < 10; c++) begin
      if (c > 0) @(negedge clk);
      if (!bus_cs_n[area]) begin
        win_len++;
        if (bus_addr != addr) addr_bad++;
        if (c >= exp_len) late_win++;
      end
      if ((~bus_cs_n & ~(NA'(1) << area)) != '0) other_bad++;
      if (!bus_rd_n || !bus_wr_n) begin
        stb_cnt++;
        stb_idx = c;
        if (wr ? !bus_rd_n : !bus_wr_n) wrong_stb++;
      end
      if (wr && c >= 1 + pre && c < exp_len) begin
        if (!bus_doe || bus_dout != wd) doe_bad++;
      end else if (bus_doe) doe_bad++;
      if (done) begin
        done_cnt++;
        done_idx = c;
        rd_at_done = rd_data;
        if (bus_cs_n != '1) other_bad++;
      end
      if (mode == 1 && c == 1) begin
        req_area = 3'((area + 1) % NA); req_start = 1'b1;
      end
      if (mode == 1 && c == 2) req_start = 1'b0;
      if (mode == 2 && c == 0) begin
        cfg_sel = 1'b0; cfg_wdata = '1; cfg_we = 1'b1;
      end
      if (mode == 2 && c == 1) cfg_we = 1'b0;
    end
    // R3 window length and lone select
    chk(win_len == exp_len, {tag, " R3 window length"}, win_len, exp_len);
    chk(other_bad == 0 && addr_bad == 0, {tag, " R3 other selects/address"},
        other_bad + addr_bad, 0);
    // R4 / R5 strobe placement inside the window
    chk(stb_idx == 1 + pre, {tag, " R4 R5 strobe position"}, stb_idx, 1 + pre);
    // R6 single correct strobe
    chk(stb_cnt == 1 && wrong_stb == 0, {tag, " R6 strobe count/type"}, stb_cnt, 1);
    // R7 data drive span
    chk(doe_bad == 0, {tag, " R7 data drive"}, doe_bad, 0);
    // R9 done right after window
    chk(done_cnt == 1 && done_idx == exp_len, {tag, " R9 done timing"}, done_idx, exp_len);
    if (!wr) chk(rd_at_done == bus_din, {tag, " R8 read capture"}, rd_at_done, bus_din);
    if (mode == 1) chk(late_win == 0, {tag, " R10 start ignored while busy"}, late_win, 0);
  endtask

  task automatic t_reset();
    logic [NA-1:0] v;
    chk(bus_cs_n == '1, "R1 cs idle", bus_cs_n, 8'hff);
    chk(bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_rd_n, bus_wr_n}, 2'b11);
    chk(!done && !bus_doe, "R1 done/doe low", {done, bus_doe}, 0);
    cfg_read(1'b0, v); chk(v == '0, "R1 lead reg reset", v, 0);
    cfg_read(1'b1, v); chk(v == '0, "R1 trail reg reset", v, 0);
  endtask

  task automatic t_regs();
    logic [NA-1:0] v;
    cfg_write(1'b0, 8'hA5);
    cfg_write(1'b1, 8'h3C);
    cfg_read(1'b0, v); chk(v == 8'hA5, "R2 lead readback", v, 8'hA5);
    cfg_read(1'b1, v); chk(v == 8'h3C, "R2 trail readback", v, 8'h3C);
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h00);
  endtask

  task automatic t_plain();
    bus_din = 16'h1234;
    run_access(2, 24'h00_1000, 1'b1, 16'hBEEF, 0, 0, 0, "plain write");
    run_access(5, 24'h50_0004, 1'b0, 16'h0000, 0, 0, 0, "plain read");
  endtask

  task automatic t_pre();
    cfg_write(1'b0, 8'h08);
    bus_din = 16'h55AA;
    run_access(3, 24'h30_0010, 1'b1, 16'hC0DE, 1, 0, 0, "R4 pre write");
    run_access(3, 24'h30_0012, 1'b0, 16'h0, 1, 0, 0, "R4 pre read");
    run_access(4, 24'h40_0000, 1'b1, 16'h0F0F, 0, 0, 0, "R4 neighbour area");
    cfg_write(1'b0, 8'h00);
  endtask

  task automatic t_post();
    cfg_write(1'b1, 8'h80);
    bus_din = 16'hA001;
    run_access(7, 24'h70_0020, 1'b1, 16'h7777, 0, 1, 0, "R5 post write");
    run_access(7, 24'h70_0022, 1'b0, 16'h0, 0, 1, 0, "R5 post read");
    cfg_write(1'b1, 8'h00);
  endtask

  task automatic t_both();
    cfg_write(1'b0, 8'h01);
    cfg_write(1'b1, 8'h01);
    bus_din = 16'h9009;
    run_access(0, 24'h00_0040, 1'b1, 16'h4242, 1, 1, 0, "R4 R5 both write");
    run_access(0, 24'h00_0044, 1'b0, 16'h0, 1, 1, 0, "R4 R5 both read");
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h00);
  endtask

  task automatic t_busy();
    // R10 a start mid-access must not create a second window
    run_access(1, 24'h10_0000, 1'b1, 16'h1111, 0, 0, 1, "R10 busy");
    chk(bus_cs_n == '1, "R10 idle after access", bus_cs_n, 8'hff);
  endtask

  task automatic t_latch();
    // R11 lead bits set mid-access apply only to the next access
    run_access(6, 24'h60_0000, 1'b1, 16'h6666, 0, 0, 2, "R11 current access");
    run_access(6, 24'h60_0002, 1'b1, 16'h6667, 1, 0, 0, "R11 next access");
    cfg_write(1'b0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_plain();
    t_pre();
    t_post();
    t_both();
    t_busy();
    t_latch();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule